// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Target

This block is a byte-addressed non-volatile memory target that sits on a two-wire serial bus. It watches oversampled clock and data lines, recognises Start and Stop conditions, answers only to its own device-select byte, and takes a two-byte word address. It can then accept a burst of data bytes or return a stream of stored bytes. The bus data line is driven through an open-drain pull-down output. The system side ties three device-address pins to pick one of eight positions on a shared bus, and holds a write-protect pin that can freeze the array.

Written bytes first land in a page latch. The array itself is updated only after the bus master ends the transfer with a Stop. At that point a self-timed internal write cycle begins, and for its whole length the target stays off the bus. A master can poll for completion by sending device-select bytes until one is acknowledged. Reads can begin at an explicit address (a write that carries only the address, then a repeated Start). They can also resume from the internal pointer, and they keep going until the master withholds its acknowledge. The array depth, page size, write-cycle length and synchroniser depth are parameters. The default depth is kept small so that a simulation model stays light. `ADDR_BITS=14` gives a 16K x 8 array.

Top module: `i2c_eeprom_target`

## Requirements
- R1: A falling SDA while SCL is high is a Start, and it begins a new command from any state. A rising SDA while SCL is high is a Stop, and it ends the command. Bytes clocked without a preceding Start get no acknowledge.
- R2: After each byte it accepts, the target holds SDA low for the whole ninth clock. It only ever starts pulling SDA low while SCL is low, and SDA is released coming out of reset.
- R3: The first byte after a Start is acknowledged only if bits 7:4 equal 1010 and bits 3:1 equal `dev_pins_i`. Bit 0 selects read (1) or write (0). Any other byte gets no acknowledge and is ignored until the next Start.
- R4: The word address arrives as a high byte followed by a low byte. The address used is {high[5:0], low}, reduced to its low `ADDR_BITS` bits. Bits high[7:6] and any bits at or above `ADDR_BITS` have no effect.
- R5: Each data byte is stored in the page latch at the slot given by the low log2(`PAGE_BYTES`) address bits (6 by default). That offset wraps inside the page. A later byte for the same slot replaces the earlier one. Only the slots that were loaded are committed, and every other address keeps its contents.
- R6: A Stop that follows at least one data byte, with `wp_i` low at the Stop, starts a self-timed internal cycle of `WR_CYCLES` clocks (never fewer than `PAGE_BYTES`+2). That cycle commits the latch to the array. A write transfer that ends with no data bytes starts no cycle.
- R7: While the internal cycle runs, the target acknowledges no byte, including its own device-select byte.
- R8: With `wp_i` high at the Stop, every byte is still acknowledged, but no internal cycle starts and the array is unchanged.
- R9: A random read works as follows: a write device-select and two address bytes, then a repeated Start and a read device-select. The first byte returned is the one at that address.
- R10: Read bytes go out MSB first, and each bit changes only while SCL is low. When the master acknowledges a byte, the byte at the next address follows. After a byte the master does not acknowledge, SDA stays released until the next Start. A read device-select with no address phase resumes one past the last byte sent.
- R11: The read address rolls over from 2^`ADDR_BITS`-1 to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oversampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (resolved wire) |
| dev_pins_i | input | 3 | Device position on the bus |
| wp_i | input | 1 | Write protect, high blocks commits |
| sda_pd_o | output | 1 | High pulls the data line low |

## Verification
Two functions can fall on the same clock. One is the commit walker writing latch slots into the array; the other is the protocol engine deciding whether to answer a device-select byte. The bench provokes this by polling with a device-select byte right after every Stop that ends a write. It judges the result by the missing acknowledge at that moment, by an acknowledge once the cycle has elapsed, and by the stored data read back afterwards. A second coincidence is the Stop itself with the write-protect level. Here the bench drops protection only after the Stop and expects an immediate acknowledge together with unchanged data.

// File: rtl/i2c_ee_pkg.sv
package i2c_ee_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_AHI,
    ST_ALO,
    ST_WDAT,
    ST_ACK,
    ST_TX,
    ST_MACK
  } ee_state_e;

  localparam logic [3:0] FAMILY_CODE = 4'b1010;

  function automatic logic [15:0] low_mask(input int unsigned bits);
    return 16'((32'd1 << bits) - 32'd1);
  endfunction

  // two address bytes -> word address; top two bits of the high byte dropped
  function automatic logic [15:0] word_addr(input logic [7:0] hi, input logic [7:0] lo,
                                            input int unsigned abits);
    return {2'b00, hi[5:0], lo} & low_mask(abits);
  endfunction

  // advance inside the current page, upper bits held
  function automatic logic [15:0] page_step(input logic [15:0] a, input int unsigned offb);
    logic [15:0] m;
    m = low_mask(offb);
    return (a & ~m) | ((a + 16'd1) & m);
  endfunction

  // advance across the whole array with rollover
  function automatic logic [15:0] seq_step(input logic [15:0] a, input int unsigned abits);
    return (a + 16'd1) & low_mask(abits);
  endfunction

endpackage

// File: rtl/i2c_ee_line_sync.sv
module i2c_ee_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  localparam int N = (STAGES < 2) ? 2 : STAGES;

  logic [N-1:0] scl_pipe;
  logic [N-1:0] sda_pipe;
  logic         scl_prev;
  logic         sda_prev;

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            scl_pipe[0] <= 1'b1;
            sda_pipe[0] <= 1'b1;
          end else begin
            scl_pipe[0] <= scl_i;
            sda_pipe[0] <= sda_i;
          end
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            scl_pipe[g] <= 1'b1;
            sda_pipe[g] <= 1'b1;
          end else begin
            scl_pipe[g] <= scl_pipe[g-1];
            sda_pipe[g] <= sda_pipe[g-1];
          end
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_prev <= scl_pipe[N-1];
      sda_prev <= sda_pipe[N-1];
    end
  end

  always_comb begin
    scl_lvl   = scl_pipe[N-1];
    sda_lvl   = sda_pipe[N-1];
    scl_rise  = scl_lvl & ~scl_prev;
    scl_fall  = ~scl_lvl & scl_prev;
    start_evt = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
    stop_evt  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;
  end

endmodule

// File: rtl/i2c_ee_store.sv
module i2c_ee_store #(
  parameter int ADDR_BITS  = 11,
  parameter int PAGE_BYTES = 64
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [ADDR_BITS-1:0]          rd_addr,
  output logic [7:0]                    rd_data,
  input  logic                          lat_we,
  input  logic [$clog2(PAGE_BYTES)-1:0] lat_off,
  input  logic [7:0]                    lat_data,
  input  logic                          lat_clear,
  input  logic                          commit_go,
  input  logic [ADDR_BITS-$clog2(PAGE_BYTES)-1:0] commit_page,
  output logic                          mem_we,
  output logic                          walking
);
  localparam int DEPTH = 1 << ADDR_BITS;
  localparam int OFFB  = $clog2(PAGE_BYTES);
  localparam int PW    = ADDR_BITS - OFFB;

  logic [7:0]            mem      [DEPTH];
  logic [7:0]            page_buf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] loaded;
  logic [OFFB-1:0]       idx;
  logic [PW-1:0]         page_q;
  logic [ADDR_BITS-1:0]  wr_addr;
  logic                  walk_last;

  always_comb begin
    rd_data   = mem[rd_addr];
    wr_addr   = {page_q, idx};
    mem_we    = walking && loaded[idx];
    walk_last = (idx == OFFB'(PAGE_BYTES - 1));
  end

  always_ff @(posedge clk) begin
    if (mem_we) mem[wr_addr] <= page_buf[idx];
    if (lat_we) page_buf[lat_off] <= lat_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loaded  <= '0;
      walking <= 1'b0;
      idx     <= '0;
      page_q  <= '0;
    end else begin
      if (commit_go) begin
        walking <= 1'b1;
        idx     <= '0;
        page_q  <= commit_page;
      end else if (walking) begin
        idx <= idx + OFFB'(1);
        if (walk_last) begin
          walking <= 1'b0;
          loaded  <= '0;
        end
      end else if (lat_clear) begin
        loaded <= '0;
      end else if (lat_we) begin
        loaded[lat_off] <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/i2c_ee_wr_timer.sv
module i2c_ee_wr_timer #(
  parameter int CYCLES = 250000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kick,
  output logic busy
);
  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      busy <= 1'b0;
    end else if (kick) begin
      cnt  <= CW'(CYCLES);
      busy <= 1'b1;
    end else if (busy) begin
      cnt <= cnt - CW'(1);
      if (cnt == CW'(1)) busy <= 1'b0;
    end
  end

endmodule

// File: rtl/i2c_eeprom_target.sv
module i2c_eeprom_target
  import i2c_ee_pkg::*;
#(
  parameter int ADDR_BITS   = 11,
  parameter int PAGE_BYTES  = 64,
  parameter int WR_CYCLES   = 250000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] dev_pins_i,
  input  logic       wp_i,
  output logic       sda_pd_o
);
  localparam int OFFB     = $clog2(PAGE_BYTES);
  localparam int PW       = ADDR_BITS - OFFB;
  localparam int BUSY_CYC = (WR_CYCLES > PAGE_BYTES + 2) ? WR_CYCLES : PAGE_BYTES + 2;

  // bus events
  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_evt, stop_evt;

  // engine state
  ee_state_e            state, ack_next;
  logic [3:0]           bitcnt;
  logic [7:0]           shreg;
  logic [7:0]           hi_q;
  logic [ADDR_BITS-1:0] addr_q;
  logic                 pd_q;
  logic                 wr_pending;

  // named internal events
  logic                 rx_state, byte_done, dev_match;
  logic                 lat_we, lat_clear, commit_go;
  logic                 busy, mem_we, walking;
  logic [7:0]           rd_data;
  logic [ADDR_BITS-1:0] addr_set, addr_page_nxt, addr_seq_nxt;

  i2c_ee_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_lvl   (scl_lvl),
    .sda_lvl   (sda_lvl),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_evt (start_evt),
    .stop_evt  (stop_evt)
  );

  always_comb begin
    rx_state      = state inside {ST_DEV, ST_AHI, ST_ALO, ST_WDAT};
    byte_done     = rx_state && scl_fall && (bitcnt == 4'd8) && !start_evt && !stop_evt;
    dev_match     = (shreg[7:4] == FAMILY_CODE) && (shreg[3:1] == dev_pins_i);
    lat_we        = byte_done && (state == ST_WDAT);
    lat_clear     = start_evt && !busy;
    commit_go     = stop_evt && wr_pending && !wp_i && !busy;
    addr_set      = ADDR_BITS'(word_addr(hi_q, shreg, ADDR_BITS));
    addr_page_nxt = ADDR_BITS'(page_step(16'(addr_q), OFFB));
    addr_seq_nxt  = ADDR_BITS'(seq_step(16'(addr_q), ADDR_BITS));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      ack_next   <= ST_IDLE;
      bitcnt     <= '0;
      shreg      <= '0;
      hi_q       <= '0;
      addr_q     <= '0;
      pd_q       <= 1'b0;
      wr_pending <= 1'b0;
    end else if (start_evt) begin
      state      <= ST_DEV;
      bitcnt     <= '0;
      pd_q       <= 1'b0;
      wr_pending <= 1'b0;
    end else if (stop_evt) begin
      state      <= ST_IDLE;
      pd_q       <= 1'b0;
      wr_pending <= 1'b0;
    end else begin
      case (state)
        ST_DEV, ST_AHI, ST_ALO, ST_WDAT: begin
          if (scl_rise && bitcnt < 4'd8) begin
            shreg  <= {shreg[6:0], sda_lvl};
            bitcnt <= bitcnt + 4'd1;
          end else if (byte_done) begin
            bitcnt <= '0;
            pd_q   <= 1'b1;
            state  <= ST_ACK;
            if (state == ST_DEV) begin
              if (dev_match && !busy) begin
                ack_next <= shreg[0] ? ST_TX : ST_AHI;
              end else begin
                pd_q  <= 1'b0;
                state <= ST_IDLE;
              end
            end else if (state == ST_AHI) begin
              hi_q     <= shreg;
              ack_next <= ST_ALO;
            end else if (state == ST_ALO) begin
              addr_q   <= addr_set;
              ack_next <= ST_WDAT;
            end else begin
              addr_q     <= addr_page_nxt;
              wr_pending <= 1'b1;
              ack_next   <= ST_WDAT;
            end
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            state  <= ack_next;
            bitcnt <= '0;
            if (ack_next == ST_TX) begin
              shreg <= rd_data;
              pd_q  <= ~rd_data[7];
            end else begin
              pd_q <= 1'b0;
            end
          end
        end
        ST_TX: begin
          if (scl_rise && bitcnt < 4'd8) begin
            bitcnt <= bitcnt + 4'd1;
          end else if (scl_fall) begin
            if (bitcnt == 4'd8) begin
              pd_q   <= 1'b0;
              addr_q <= addr_seq_nxt;
              state  <= ST_MACK;
            end else begin
              shreg <= {shreg[6:0], 1'b0};
              pd_q  <= ~shreg[6];
            end
          end
        end
        ST_MACK: begin
          if (scl_rise && sda_lvl) begin
            state <= ST_IDLE;
          end else if (scl_fall) begin
            shreg  <= rd_data;
            pd_q   <= ~rd_data[7];
            bitcnt <= '0;
            state  <= ST_TX;
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_pd_o = pd_q;

  i2c_ee_store #(.ADDR_BITS(ADDR_BITS), .PAGE_BYTES(PAGE_BYTES)) u_store (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_addr     (addr_q),
    .rd_data     (rd_data),
    .lat_we      (lat_we),
    .lat_off     (addr_q[OFFB-1:0]),
    .lat_data    (shreg),
    .lat_clear   (lat_clear),
    .commit_go   (commit_go),
    .commit_page (addr_q[ADDR_BITS-1:OFFB]),
    .mem_we      (mem_we),
    .walking     (walking)
  );

  i2c_ee_wr_timer #(.CYCLES(BUSY_CYC)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .kick  (commit_go),
    .busy  (busy)
  );

endmodule

// File: rtl/i2c_ee_checker.sv
module i2c_ee_checker (
  input logic clk,
  input logic rst_n,
  input logic scl_lvl,
  input logic sda_pd_o,
  input logic busy,
  input logic wp_i,
  input logic mem_we,
  input logic start_evt,
  input logic stop_evt,
  input logic commit_go
);

  p_start_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> !sda_pd_o);

  p_stop_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !sda_pd_o);

  p_pull_scl_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pd_o) |-> !scl_lvl);

  p_commit_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    commit_go |=> busy);

  p_array_write_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy);

  p_silent_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !sda_pd_o);

  p_protect_commit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    commit_go |-> !wp_i);

endmodule

bind i2c_eeprom_target i2c_ee_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .scl_lvl   (scl_lvl),
  .sda_pd_o  (sda_pd_o),
  .busy      (busy),
  .wp_i      (wp_i),
  .mem_we    (mem_we),
  .start_evt (start_evt),
  .stop_evt  (stop_evt),
  .commit_go (commit_go)
);

// File: tb/test_i2c_eeprom_target.sv
module test_i2c_eeprom_target;

  localparam int AW  = 11;
  localparam int PB  = 64;
  localparam int WRC = 400;
  localparam int Q   = 10;
  localparam logic [2:0] PINS  = 3'b101;
  localparam logic [7:0] DEV_W = {4'b1010, PINS, 1'b0};
  localparam logic [7:0] DEV_R = {4'b1010, PINS, 1'b1};
  localparam int NVEC = 8;
  // {word address, data}
  localparam logic [23:0] VEC [NVEC] = '{
    {16'h0001, 8'h3C}, {16'h0042, 8'h5D}, {16'h0080, 8'h11}, {16'h0233, 8'h9E},
    {16'h07FF, 8'h77}, {16'h0000, 8'h88}, {16'h0400, 8'hA5}, {16'h02C7, 8'h6B}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic wp = 1'b0;
  logic sda_pd;
  logic sda_bus;
  int   nchk = 0;
  int   nfail = 0;
  bit   done = 1'b0;

  always #10 clk = ~clk;
  assign sda_bus = sda_m & ~sda_pd;

  i2c_eeprom_target #(.ADDR_BITS(AW), .PAGE_BYTES(PB), .WR_CYCLES(WRC)) i_i2c_eeprom_target (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl_m),
    .sda_i      (sda_bus),
    .dev_pins_i (PINS),
    .wp_i       (wp),
    .sda_pd_o   (sda_pd)
  );

  task automatic qwait();
    repeat (Q) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp,
                     input string what);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic start_c();
    sda_m = 1'b1; qwait();
    scl_m = 1'b1; qwait();
    sda_m = 1'b0; qwait();
    scl_m = 1'b0; qwait();
  endtask

  task automatic stop_c();
    sda_m = 1'b0; qwait();
    scl_m = 1'b1; qwait();
    sda_m = 1'b1; qwait();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; qwait();
      scl_m = 1'b1; qwait();
      scl_m = 1'b0; qwait();
    end
    sda_m = 1'b1; qwait();
    scl_m = 1'b1;
    repeat (Q / 2) @(negedge clk);
    ack = ~sda_bus;
    repeat (Q / 2) @(negedge clk);
    scl_m = 1'b0; qwait();
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      qwait();
      scl_m = 1'b1;
      repeat (Q / 2) @(negedge clk);
      b[i] = sda_bus;
      repeat (Q / 2) @(negedge clk);
      scl_m = 1'b0;
    end
    sda_m = ~give_ack; qwait();
    scl_m = 1'b1; qwait();
    scl_m = 1'b0; qwait();
    sda_m = 1'b1;
  endtask

  task automatic set_addr(input logic [15:0] a, input string tag);
    logic ack;
    start_c();
    send_byte(DEV_W, ack);  chk(tag, 32'(ack), 1, "write select ack");
    send_byte(a[15:8], ack); chk(tag, 32'(ack), 1, "high address ack");
    send_byte(a[7:0], ack);  chk(tag, 32'(ack), 1, "low address ack");
  endtask

  task automatic write_run(input logic [15:0] a, input int n, input logic [7:0] first,
                           input string tag);
    logic ack;
    set_addr(a, tag);
    for (int i = 0; i < n; i++) begin
      send_byte(first + 8'(i), ack);
      chk(tag, 32'(ack), 1, "data ack");
    end
    stop_c();
  endtask

  task automatic read_at(input logic [15:0] a, output logic [7:0] b);
    logic ack;
    set_addr(a, "R9");
    start_c();
    send_byte(DEV_R, ack); chk("R9", 32'(ack), 1, "read select ack");
    recv_byte(1'b0, b);
    stop_c();
  endtask

  task automatic poll_once(output logic ack);
    start_c();
    send_byte(DEV_W, ack);
    stop_c();
  endtask

  task automatic wait_ready(output int polls);
    logic ack;
    polls = 0;
    ack = 1'b0;
    while (!ack && polls < 40) begin
      poll_once(ack);
      polls++;
    end
  endtask

  initial begin
    repeat (200000 - 10000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL R1 watchdog: actual=hung expected=completed");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic       ack;
    logic [7:0] b;
    int         polls;

    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R2", 32'(sda_pd), 0, "data line released after reset");

    // vector table: write one byte, poll while busy, read back at random
    for (int v = 0; v < NVEC; v++) begin
      write_run(VEC[v][23:8], 1, VEC[v][7:0], "R2");
      poll_once(ack);
      chk("R7", 32'(ack), 0, "select ack during write cycle");
      wait_ready(polls);
      chk("R6", 32'(polls < 40), 1, "write cycle ends");
      read_at(VEC[v][23:8], b);
      chk("R6", 32'(b), 32'(VEC[v][7:0]), "committed byte");
    end

    // R1: byte without a Start is ignored
    scl_m = 1'b0; qwait();
    send_byte(DEV_W, ack);
    chk("R1", 32'(ack), 0, "ack without Start");
    stop_c();

    // R1 / R3: mismatched select, then a repeated Start restarts the command
    start_c();
    send_byte(8'hFF, ack);
    chk("R3", 32'(ack), 0, "foreign select byte");
    start_c();
    send_byte(DEV_W, ack);
    chk("R1", 32'(ack), 1, "select after repeated Start");
    stop_c();
    start_c();
    send_byte({4'b1010, PINS ^ 3'b001, 1'b0}, ack);
    chk("R3", 32'(ack), 0, "other pin position");
    stop_c();
    start_c();
    send_byte({4'b1011, PINS, 1'b0}, ack);
    chk("R3", 32'(ack), 0, "other family code");
    stop_c();

    // R4: ignored address bits
    write_run(16'hC123, 1, 8'hD4, "R4");
    wait_ready(polls);
    read_at(16'h0123, b);
    chk("R4", 32'(b), 32'hD4, "high two bits ignored");
    read_at(16'h3923, b);
    chk("R4", 32'(b), 32'hD4, "bits above array ignored");

    // R5: wrap inside the page starting at offset 0x3E of page 0x040
    write_run(16'h007E, 4, 8'hA0, "R5");
    wait_ready(polls);
    read_at(16'h007E, b); chk("R5", 32'(b), 32'hA0, "slot 0x7E");
    read_at(16'h007F, b); chk("R5", 32'(b), 32'hA1, "slot 0x7F");
    read_at(16'h0040, b); chk("R5", 32'(b), 32'hA2, "wrapped to 0x40");
    read_at(16'h0041, b); chk("R5", 32'(b), 32'hA3, "wrapped to 0x41");
    read_at(16'h0042, b); chk("R5", 32'(b), 32'h5D, "unloaded slot kept");
    read_at(16'h0080, b); chk("R5", 32'(b), 32'h11, "next page kept");

    // R8: write protect at the Stop
    wp = 1'b1;
    write_run(16'h0080, 1, 8'hEE, "R8");
    wp = 1'b0;
    poll_once(ack);
    chk("R8", 32'(ack), 1, "no write cycle under protect");
    read_at(16'h0080, b);
    chk("R8", 32'(b), 32'h11, "array unchanged under protect");

    // R6: address only, no data bytes
    set_addr(16'h0200, "R6");
    stop_c();
    poll_once(ack);
    chk("R6", 32'(ack), 1, "no cycle without data");

    // R5 / R10: 66 bytes into one page, then a full sequential read
    write_run(16'h0100, PB + 2, 8'h20, "R5");
    wait_ready(polls);
    set_addr(16'h0100, "R9");
    start_c();
    send_byte(DEV_R, ack);
    chk("R9", 32'(ack), 1, "read select ack");
    for (int k = 0; k < PB; k++) begin
      recv_byte(k != PB - 1, b);
      chk("R10", 32'(b), (k < 2) ? 32'(8'h20 + 8'(PB + k)) : 32'(8'h20 + 8'(k)),
          "sequential page byte");
    end
    qwait();
    chk("R10", 32'(sda_bus), 1, "line released after no-ack");
    stop_c();

    // R11: rollover, then resume from the pointer
    set_addr(16'h07FF, "R9");
    start_c();
    send_byte(DEV_R, ack);
    recv_byte(1'b1, b); chk("R11", 32'(b), 32'h77, "last address");
    recv_byte(1'b0, b); chk("R11", 32'(b), 32'h88, "rolled to zero");
    stop_c();
    start_c();
    send_byte(DEV_R, ack);
    chk("R10", 32'(ack), 1, "resume select ack");
    recv_byte(1'b0, b);
    chk("R10", 32'(b), 32'h3C, "resumed at address 1");
    stop_c();

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule